// File: doc/BRIEF.md
# Hierarchical Lookahead Adder/Subtractor

This block adds or subtracts two unsigned or two's-complement operands in a single combinational pass. The operand is split into equal groups of bits. Each group forms its own carries directly from the per-bit propagate and generate terms and its incoming carry. A second lookahead stage takes the propagate/generate pair of every group and forms all of the group carries at once, so no carry ripples from one group to the next.

In subtract mode the second operand is inverted and the carry-in is forced to one, which yields `a - b`. The block reports the carry-out and the signed overflow. It also exports a propagate/generate pair for the whole word, so a wider adder can treat this block as one group of a further lookahead level.

Top module: `cla_adder`

## Requirements
- R1: With `sub`=0, `{cout, sum}` equals `a + b + cin`, taken over WIDTH+1 bits.
- R2: With `sub`=1, `sum` equals `(a - b)` modulo 2^WIDTH, and `cin` has no effect on `sum`, `cout`, `ovf`, `blk_p` or `blk_g`.
- R3: With `sub`=1, `cout` is 1 exactly when `a` >= `b` as unsigned numbers, meaning no borrow occurs.
- R4: `ovf` is 1 exactly when the two's-complement result of the selected operation, read as signed, lies outside the range from -2^(WIDTH-1) to 2^(WIDTH-1)-1.
- R5: `blk_p` is 1 exactly when every bit of `a` differs from the matching bit of the effective second operand. The effective operand is `b` in add mode and `~b` in subtract mode, so in subtract mode `blk_p` is 1 exactly when `a` == `b`.
- R6: `blk_g` is 1 exactly when the operation, evaluated with a carry-in of 0, carries out. That means `a + b` > 2^WIDTH-1 in add mode, and `a` > `b` in subtract mode.
- R7: `cout` always equals `blk_g | (blk_p & c0)`, where c0 is `cin` in add mode and 1 in subtract mode. This relation lets the block be cascaded.
- R8: A carry that starts at bit 0 and must travel through every bit position gives the correct result. For example, 16'hFFFF + 16'h0001 gives `sum`=0 and `cout`=1, and a carry that has to cross exactly one group boundary also gives the correct result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry-in for add mode; ignored in subtract mode |
| sub | input | 1 | 0 = add, 1 = subtract (a - b) |
| sum | output | WIDTH | Result |
| cout | output | 1 | Carry-out of the most significant bit |
| ovf | output | 1 | Signed overflow |
| blk_p | output | 1 | Propagate term for the whole word |
| blk_g | output | 1 | Generate term for the whole word |

## Verification
The bench builds the adder with WIDTH=16 and GROUP=4. That gives four groups, so the second lookahead stage handles three inter-group carries as well as the exported pair, and every carry path from bit 0 to bit 15 can be reached. Directed operands drive a carry across one group boundary and across all of them. They also hit both signed overflow directions in each mode and the equal-operand case in subtract mode. Random operands in both modes, with `cin` toggled, cover the rest.

// File: rtl/cla_pkg.sv
package cla_pkg;

   // propagate / generate pair handed from one lookahead level to the next
   typedef struct packed {
      logic p;
      logic g;
   } pg_t;

endpackage

// File: rtl/cla_lookahead.sv
// Flat lookahead: every carry is an OR of products of p, g and the incoming carry.
module cla_lookahead #(
   parameter int N = 4
) (
   input  logic [N-1:0] p,
   input  logic [N-1:0] g,
   input  logic         c0,
   output logic [N-1:0] cvec,   // carry into each position, cvec[0] = c0
   output logic         pg_p,
   output logic         pg_g
);

   initial begin
      if (N < 1) $error("cla_lookahead: N must be at least 1");
   end

   always_comb begin
      logic acc;
      logic run;
      cvec[0] = c0;
      for (int i = 0; i < N - 1; i++) begin
         run = c0;
         for (int k = 0; k <= i; k++) run = run & p[k];
         acc = run;
         for (int j = 0; j <= i; j++) begin
            run = g[j];
            for (int k = j + 1; k <= i; k++) run = run & p[k];
            acc = acc | run;
         end
         cvec[i+1] = acc;
      end
   end

   always_comb begin
      logic acc;
      logic run;
      pg_p = &p;
      acc = 1'b0;
      for (int j = 0; j < N; j++) begin
         run = g[j];
         for (int k = j + 1; k < N; k++) run = run & p[k];
         acc = acc | run;
      end
      pg_g = acc;
   end

endmodule

// File: rtl/cla_group.sv
// One group: per-bit p/g, internal lookahead carries, sum, exported group pair.
module cla_group
   import cla_pkg::*;
#(
   parameter int GW = 4
) (
   input  logic [GW-1:0] a,
   input  logic [GW-1:0] b,
   input  logic          cin,
   output logic [GW-1:0] sum,
   output pg_t           grp
);

   logic [GW-1:0] bit_p;
   logic [GW-1:0] bit_g;
   logic [GW-1:0] carry;
   logic          gp;
   logic          gg;

   assign bit_p = a ^ b;
   assign bit_g = a & b;

   cla_lookahead #(.N(GW)) u_la (
      .p    (bit_p),
      .g    (bit_g),
      .c0   (cin),
      .cvec (carry),
      .pg_p (gp),
      .pg_g (gg)
   );

   assign sum   = bit_p ^ carry;
   assign grp.p = gp;
   assign grp.g = gg;

endmodule

// File: rtl/cla_adder.sv
module cla_adder
   import cla_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int GROUP = 4
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf,
   output logic             blk_p,
   output logic             blk_g
);

   localparam int NGRP = WIDTH / GROUP;
   localparam int MSB  = WIDTH - 1;

   generate
      if (GROUP < 1 || WIDTH < GROUP || (WIDTH % GROUP) != 0) begin : g_bad_cfg
         $error("cla_adder: WIDTH must be a positive multiple of GROUP");
      end
   endgenerate

   logic [WIDTH-1:0] b_eff;
   logic             c0;
   pg_t  [NGRP-1:0]  grp_pg;
   logic [NGRP-1:0]  grp_p;
   logic [NGRP-1:0]  grp_g;
   logic [NGRP-1:0]  grp_cin;

   // subtract: invert b and force the carry-in
   assign b_eff = b ^ {WIDTH{sub}};
   assign c0    = cin | sub;

   genvar gi;
   generate
      for (gi = 0; gi < NGRP; gi++) begin : g_grp
         cla_group #(.GW(GROUP)) u_grp (
            .a   (a[gi*GROUP +: GROUP]),
            .b   (b_eff[gi*GROUP +: GROUP]),
            .cin (grp_cin[gi]),
            .sum (sum[gi*GROUP +: GROUP]),
            .grp (grp_pg[gi])
         );
         assign grp_p[gi] = grp_pg[gi].p;
         assign grp_g[gi] = grp_pg[gi].g;
      end
   endgenerate

   // second level: all group carries in parallel
   cla_lookahead #(.N(NGRP)) u_top_la (
      .p    (grp_p),
      .g    (grp_g),
      .c0   (c0),
      .cvec (grp_cin),
      .pg_p (blk_p),
      .pg_g (blk_g)
   );

   assign cout = blk_g | (blk_p & c0);

   // carry into the sign bit recovered from its sum and propagate
   logic c_into_msb;
   assign c_into_msb = sum[MSB] ^ a[MSB] ^ b_eff[MSB];
   assign ovf        = c_into_msb ^ cout;

endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
   parameter int WIDTH = 16
) (
   input logic [WIDTH-1:0] a,
   input logic [WIDTH-1:0] b,
   input logic             cin,
   input logic             sub,
   input logic [WIDTH-1:0] sum,
   input logic             cout,
   input logic             ovf,
   input logic             blk_p,
   input logic             blk_g
);

   logic [WIDTH:0] wide;
   logic           known;

   always_comb begin
      known = !$isunknown({a, b, cin, sub, sum, cout, ovf, blk_p, blk_g});
      wide  = sub ? ({1'b0, a} + {1'b0, ~b} + {{WIDTH{1'b0}}, 1'b1})
                  : ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin});
      if (known) begin
         AST_ADD_RESULT: assert (sub || {cout, sum} == wide);                          // R1
         AST_SUB_RESULT: assert (!sub || sum == WIDTH'(a - b));                        // R2
         AST_NO_BORROW:  assert (!sub || cout == (a >= b));                            // R3
         AST_OVERFLOW:   assert (ovf == ((a[WIDTH-1] == (b[WIDTH-1] ^ sub)) &&
                                         (sum[WIDTH-1] != a[WIDTH-1])));               // R4
         AST_BLOCK_P:    assert (blk_p == ((a ^ b ^ {WIDTH{sub}}) == {WIDTH{1'b1}}));  // R5
         AST_CASCADE:    assert (cout == (blk_g | (blk_p & (cin | sub))));             // R7
      end
   end

endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH)) u_chk (
   .a     (a),
   .b     (b),
   .cin   (cin),
   .sub   (sub),
   .sum   (sum),
   .cout  (cout),
   .ovf   (ovf),
   .blk_p (blk_p),
   .blk_g (blk_g)
);

// File: tb/cla_adder_tb.sv
module cla_adder_tb;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 16;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] a = '0;
   logic [W-1:0] b = '0;
   logic         cin = 1'b0;
   logic         sub = 1'b0;
   logic [W-1:0] sum;
   logic         cout, ovf, blk_p, blk_g;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cla_adder #(.WIDTH(W), .GROUP(4)) u_dut (
      .a(a), .b(b), .cin(cin), .sub(sub),
      .sum(sum), .cout(cout), .ovf(ovf), .blk_p(blk_p), .blk_g(blk_g)
   );

   task automatic chk(input string req, input longint got, input longint exp);
      n_tests++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h (a=%h b=%h cin=%0d sub=%0d)",
                  req, got, exp, a, b, cin, sub);
      end
   endtask

   // behavioural reference using integer arithmetic only
   task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb,
                        input logic tcin, input logic tsub);
      longint ua, ub, full, e_sum;
      longint sa, sb, sres;
      bit e_cout, e_ovf, e_p, e_g, c0;
      @(posedge clk);
      #1;
      a = ta; b = tb; cin = tcin; sub = tsub;
      @(negedge clk);
      ua = longint'(ta);
      ub = longint'(tb);
      sa = ua >= 32768 ? ua - 65536 : ua;
      sb = ub >= 32768 ? ub - 65536 : ub;
      if (!tsub) begin
         full   = ua + ub + longint'(tcin);
         e_sum  = full % 65536;
         e_cout = full >= 65536;
         sres   = sa + sb + longint'(tcin);
         e_p    = (ua + ub == 65535) && ((ta & tb) == 0);
         e_g    = (ua + ub) >= 65536;
         c0     = tcin;
      end else begin
         e_sum  = (ua - ub + 65536) % 65536;
         e_cout = ua >= ub;
         sres   = sa - sb;
         e_p    = ua == ub;
         e_g    = ua > ub;
         c0     = 1'b1;
      end
      e_ovf = (sres > 32767) || (sres < -32768);
      chk(tsub ? "R2 sum" : "R1 sum", longint'(sum), e_sum);
      chk(tsub ? "R3 cout" : "R1 cout", longint'(cout), longint'(e_cout));
      chk("R4 ovf", longint'(ovf), longint'(e_ovf));
      chk("R5 blk_p", longint'(blk_p), longint'(e_p));
      chk("R6 blk_g", longint'(blk_g), longint'(e_g));
      chk("R7 cascade", longint'(cout), longint'(blk_g | (blk_p & c0)));
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : stim
      logic [W-1:0] s0;
      logic         c0v;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // reset state: zero operands give zero result
      chk("R1 reset sum", longint'(sum), 0);
      chk("R1 reset cout", longint'(cout), 0);

      // R8: full-length and single-boundary carry chains
      apply(16'hFFFF, 16'h0001, 1'b0, 1'b0);
      chk("R8 chain sum", longint'(sum), 0);
      chk("R8 chain cout", longint'(cout), 1);
      apply(16'hFFFF, 16'h0000, 1'b1, 1'b0);
      chk("R8 cin chain sum", longint'(sum), 0);
      apply(16'h000F, 16'h0001, 1'b0, 1'b0);
      chk("R8 boundary sum", longint'(sum), 16'h0010);
      apply(16'h0FFF, 16'h0000, 1'b1, 1'b0);
      apply(16'hFFFF, 16'hFFFF, 1'b1, 1'b0);

      // R4 overflow corners in both modes
      apply(16'h7FFF, 16'h0001, 1'b0, 1'b0);
      chk("R4 pos ovf", longint'(ovf), 1);
      apply(16'h8000, 16'hFFFF, 1'b0, 1'b0);
      chk("R4 neg ovf", longint'(ovf), 1);
      apply(16'h8000, 16'h0001, 1'b0, 1'b1);
      chk("R4 sub ovf", longint'(ovf), 1);
      apply(16'h7FFF, 16'hFFFF, 1'b0, 1'b1);
      apply(16'h0000, 16'h8000, 1'b0, 1'b1);

      // R3 borrow, R5 equal operands in subtract mode
      apply(16'h0000, 16'h0001, 1'b0, 1'b1);
      chk("R3 borrow", longint'(cout), 0);
      apply(16'h1234, 16'h1234, 1'b0, 1'b1);
      chk("R5 equal p", longint'(blk_p), 1);
      apply(16'h5555, 16'hAAAA, 1'b0, 1'b0);
      chk("R5 alt p", longint'(blk_p), 1);

      // R2: cin has no effect in subtract mode
      for (int i = 0; i < 200; i++) begin
         logic [W-1:0] ra, rb;
         ra = W'($urandom);
         rb = W'($urandom);
         apply(ra, rb, 1'b0, 1'b1);
         s0  = sum;
         c0v = cout;
         apply(ra, rb, 1'b1, 1'b1);
         chk("R2 cin ignored sum", longint'(sum), longint'(s0));
         chk("R2 cin ignored cout", longint'(cout), longint'(c0v));
      end

      // random in both modes
      for (int i = 0; i < 3000; i++) begin
         logic [W-1:0] ra, rb;
         logic [2:0]   sel;
         sel = 3'($urandom);
         ra = W'($urandom);
         rb = sel[2] ? ~ra : W'($urandom);
         apply(ra, rb, sel[0], sel[1]);
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule